// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block picks a direction and a next-fetch address for a conditional branch at fetch time. It uses only information that is fixed when the code is compiled. A two-bit policy select chooses how the direction is decided. The block can predict every branch taken, decide from the sign of the branch displacement, or follow a bias bit that the compiler set from earlier profiling runs.

The pipeline has one delay slot after each branch, and that slot always executes. A not-taken prediction therefore points two instructions past the branch. A taken prediction points at the branch target.

Each predicted branch carries a small tag. The block keeps the direction and policy it chose for that tag. When the branch resolves later, the pipeline presents the same tag and the real outcome. The block then raises a one-cycle mispredict pulse if the guess was wrong. It also keeps a saturating count of resolved branches and a separate saturating miss count for each policy, so the policies can be compared on the same code.

Top module: `static_branch_predictor`

## Requirements
- R1: With policy select 2'b00, the predicted direction is taken for every branch, whatever the displacement and hint are.
- R2: With policy select 2'b01, the prediction is taken exactly when the displacement is negative (its most significant bit is 1), and not taken otherwise.
- R3: With policy select 2'b10, the prediction equals the hint input (1 = taken).
- R4: Policy select 2'b11 behaves exactly like 2'b00, both for the direction and for the miss counter that its branches are charged to.
- R5: When the prediction is taken, the target equals pc + 4 + (sign-extended displacement × 4), wrapped to the PC width.
- R6: When the prediction is not taken, the target equals pc + 8, which skips the delay slot.
- R7: A fetch with its valid input high records the chosen direction and policy under its tag at the clock edge. A resolve with its valid input high compares the reported outcome with the direction recorded for its tag. The mispredict output is high during the single cycle after a resolve that disagrees, and low in every other cycle.
- R8: The branch counter increments by one on each clock edge where a resolve is valid, and holds at all ones once it reaches all ones.
- R9: The miss count output packs one CNT_W-bit slice per policy: slice 0 is always-taken, slice 1 is displacement sign, and slice 2 is hint, each at bits [CNT_W*p +: CNT_W]. A slice increments only on a mispredicted resolve of a branch that was fetched under that policy, and holds at all ones.
- R10: While rst_n is low at a clock edge, both counters and the mispredict output clear to zero. Reset is synchronous.
- R11: If a fetch and a resolve use the same tag on the same edge, the resolve is compared against the record as it stood before that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Policy select (00 always taken, 01 sign of displacement, 10 hint, 11 as 00) |
| fetch_valid_i | input | 1 | A branch is being predicted this cycle |
| fetch_tag_i | input | TAG_W | Tag under which the prediction is recorded |
| pc_i | input | PC_W | Address of the branch |
| disp_i | input | OFF_W | Signed word displacement from the encoding |
| hint_i | input | 1 | Compiler bias bit, 1 = taken |
| pred_taken_o | output | 1 | Predicted direction (combinational) |
| pred_target_o | output | PC_W | Predicted next fetch address (combinational) |
| res_valid_i | input | 1 | A branch outcome is reported this cycle |
| res_tag_i | input | TAG_W | Tag of the resolving branch |
| res_taken_i | input | 1 | Actual direction |
| mispredict_o | output | 1 | One-cycle pulse after a wrong prediction resolves |
| branch_count_o | output | CNT_W | Saturating count of resolves |
| miss_count_o | output | 3*CNT_W | Saturating miss counts, one slice per policy |

## Verification
On every cycle, the in-line properties check the following. A mispredict pulse only ever follows a valid resolve. The first and last policy codes always predict taken. A not-taken prediction always points past the delay slot. The branch counter moves in single steps on resolves. A miss slice moves only after a mispredicted resolve.

Other behaviour can only be shown by the bench's scenarios, because it depends on the history of the traffic. These are whether the recorded direction for a tag is the one later compared, the exact taken-target arithmetic across the sign boundary and across address wrap, the way misses are charged to the right policy slice (including the fallback code), the ordering when a fetch and a resolve hit the same tag, and saturation at all ones.

// File: rtl/sbp_pkg.sv
// Package: shared policy type, per-branch record type and mode decode.
// Assumes a two-bit policy select; the unused code maps to always-taken.
package sbp_pkg;

    typedef enum logic [1:0] {
        POL_ALWAYS = 2'b00,
        POL_SIGN   = 2'b01,
        POL_HINT   = 2'b10
    } policy_e;

    localparam int NUM_POL = 3;

    typedef struct packed {
        logic    taken;
        policy_e pol;
    } branch_rec_t;

    // Map the raw select onto a policy; the spare code falls back to always-taken.
    function automatic policy_e decode_mode(input logic [1:0] sel);
        case (sel)
            2'b01:   return POL_SIGN;
            2'b10:   return POL_HINT;
            default: return POL_ALWAYS;
        endcase
    endfunction

endpackage

// File: rtl/sbp_policy.sv
// Module: sbp_policy
// Chooses the static direction and the next fetch address for one branch.
// Assumes a single delay slot, so the fall-through address is pc + 8, and a
// displacement counted in 4-byte words. Purely combinational.
module sbp_policy
    import sbp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [1:0]       mode_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] disp_i,
    input  logic             hint_i,
    output logic             taken_o,
    output policy_e          pol_o,
    output logic [PC_W-1:0]  target_o
);

    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] taken_addr;
    logic [PC_W-1:0] fall_addr;

    // Select the policy and derive the direction from it.
    always_comb begin
        pol_o = decode_mode(mode_i);
        case (pol_o)
            POL_SIGN: taken_o = disp_i[OFF_W-1];
            POL_HINT: taken_o = hint_i;
            default:  taken_o = 1'b1;
        endcase
    end

    // Form both candidate addresses: branch target and past the delay slot.
    always_comb begin
        disp_ext   = {{EXT_W{disp_i[OFF_W-1]}}, disp_i};
        taken_addr = pc_i + PC_W'(4) + (disp_ext << 2);
        fall_addr  = pc_i + PC_W'(8);
    end

    // Pick the address that matches the direction.
    always_comb begin
        target_o = taken_o ? taken_addr : fall_addr;
    end

endmodule

// File: rtl/sbp_record.sv
// Module: sbp_record
// Holds the direction and policy chosen for each in-flight branch tag.
// Assumes the tag space is small (2**TAG_W entries). The read is asynchronous
// and returns the value held before any write on the same edge.
module sbp_record
    import sbp_pkg::*;
#(
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  branch_rec_t      wr_rec_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    output branch_rec_t      rd_rec_o
);

    localparam int DEPTH = 1 << TAG_W;

    branch_rec_t slots_q [DEPTH];

    // Per-slot storage: cleared on reset, written when the fetch tag selects it.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots_q[s] <= '{taken: 1'b0, pol: POL_ALWAYS};
            end else if (wr_en_i && (wr_tag_i == TAG_W'(s))) begin
                slots_q[s] <= wr_rec_i;
            end
        end
    end

    // Look up the record for the resolving tag.
    always_comb begin
        rd_rec_o = slots_q[rd_tag_i];
    end

endmodule

// File: rtl/sbp_counters.sv
// Module: sbp_counters
// Saturating event counters: all resolves, and misses split by policy.
// Assumes the miss flag and policy are valid in the same cycle as res_valid_i.
module sbp_counters
    import sbp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_valid_i,
    input  logic                     miss_i,
    input  policy_e                  pol_i,
    output logic [CNT_W-1:0]         branch_cnt_o,
    output logic [NUM_POL*CNT_W-1:0] miss_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] br_q;
    logic [CNT_W-1:0] miss_q [NUM_POL];

    // Count every resolve, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_q <= '0;
        end else if (res_valid_i && (br_q != CNT_MAX)) begin
            br_q <= br_q + 1'b1;
        end
    end

    assign branch_cnt_o = br_q;

    // R8
    branch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid_i) && ($past(br_q) != CNT_MAX))
            |-> (br_q == CNT_W'($past(br_q) + 1'b1)));

    for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
        // Count misses charged to policy p, stopping at the top value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                miss_q[p] <= '0;
            end else if (res_valid_i && miss_i && (int'(pol_i) == p)
                         && (miss_q[p] != CNT_MAX)) begin
                miss_q[p] <= miss_q[p] + 1'b1;
            end
        end

        assign miss_cnt_o[p*CNT_W +: CNT_W] = miss_q[p];

        // R9
        miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && (miss_q[p] != $past(miss_q[p])))
                |-> ($past(res_valid_i) && $past(miss_i)));
    end

endmodule

// File: rtl/static_branch_predictor.sv
// Module: static_branch_predictor
// Top level: static prediction at fetch, per-tag record of the guess, and
// mispredict detection plus counting at resolve.
// Assumes at most one fetch and one resolve per cycle, and that a tag is not
// reused before its branch resolves (a reuse simply overwrites the record).
module static_branch_predictor
    import sbp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int TAG_W = 2,
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic                     fetch_valid_i,
    input  logic [TAG_W-1:0]         fetch_tag_i,
    input  logic [PC_W-1:0]          pc_i,
    input  logic [OFF_W-1:0]         disp_i,
    input  logic                     hint_i,
    output logic                     pred_taken_o,
    output logic [PC_W-1:0]          pred_target_o,
    input  logic                     res_valid_i,
    input  logic [TAG_W-1:0]         res_tag_i,
    input  logic                     res_taken_i,
    output logic                     mispredict_o,
    output logic [CNT_W-1:0]         branch_count_o,
    output logic [3*CNT_W-1:0]       miss_count_o
);

    policy_e     fetch_pol;
    branch_rec_t new_rec;
    branch_rec_t old_rec;
    logic        miss_now;
    logic        mispredict_q;

    sbp_policy #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_policy (
        .mode_i   (mode_i),
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .hint_i   (hint_i),
        .taken_o  (pred_taken_o),
        .pol_o    (fetch_pol),
        .target_o (pred_target_o)
    );

    // Bundle the decision for storage under the fetch tag.
    always_comb begin
        new_rec = '{taken: pred_taken_o, pol: fetch_pol};
    end

    sbp_record #(
        .TAG_W (TAG_W)
    ) u_record (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (fetch_valid_i),
        .wr_tag_i (fetch_tag_i),
        .wr_rec_i (new_rec),
        .rd_tag_i (res_tag_i),
        .rd_rec_o (old_rec)
    );

    // Compare the reported outcome with the stored guess.
    always_comb begin
        miss_now = res_valid_i && (old_rec.taken != res_taken_i);
    end

    // Register the miss into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mispredict_q <= 1'b0;
        end else begin
            mispredict_q <= miss_now;
        end
    end

    assign mispredict_o = mispredict_q;

    sbp_counters #(
        .CNT_W (CNT_W)
    ) u_counters (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid_i  (res_valid_i),
        .miss_i       (miss_now),
        .pol_i        (old_rec.pol),
        .branch_cnt_o (branch_count_o),
        .miss_cnt_o   (miss_count_o)
    );

    // R7
    pulse_after_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_o |-> $past(res_valid_i));

    // R1
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b00) || (mode_i == 2'b11)) |-> pred_taken_o);

    // R6
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken_o |-> (pred_target_o == pc_i + PC_W'(8)));

endmodule

// File: tb/tb_static_branch_predictor.sv
module tb_static_branch_predictor;

    localparam int PC_W  = 32;
    localparam int OFF_W = 16;
    localparam int TAG_W = 2;
    localparam int CNT_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           mode_i = '0;
    logic                 fetch_valid_i = 1'b0;
    logic [TAG_W-1:0]     fetch_tag_i = '0;
    logic [PC_W-1:0]      pc_i = '0;
    logic [OFF_W-1:0]     disp_i = '0;
    logic                 hint_i = 1'b0;
    logic                 pred_taken_o;
    logic [PC_W-1:0]      pred_target_o;
    logic                 res_valid_i = 1'b0;
    logic [TAG_W-1:0]     res_tag_i = '0;
    logic                 res_taken_i = 1'b0;
    logic                 mispredict_o;
    logic [CNT_W-1:0]     branch_count_o;
    logic [3*CNT_W-1:0]   miss_count_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of recorded guesses and counters
    bit  m_dir [4];
    int  m_pol [4];
    int  m_br;
    int  m_miss [3];

    always #5 clk = ~clk;

    static_branch_predictor #(
        .PC_W(PC_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .fetch_valid_i(fetch_valid_i), .fetch_tag_i(fetch_tag_i),
        .pc_i(pc_i), .disp_i(disp_i), .hint_i(hint_i),
        .pred_taken_o(pred_taken_o), .pred_target_o(pred_target_o),
        .res_valid_i(res_valid_i), .res_tag_i(res_tag_i),
        .res_taken_i(res_taken_i), .mispredict_o(mispredict_o),
        .branch_count_o(branch_count_o), .miss_count_o(miss_count_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_dir(input int m, input logic [15:0] d, input bit h);
        if (m == 1) return d[15];
        if (m == 2) return h;
        return 1'b1;
    endfunction

    function automatic int pol_of(input int m);
        return (m == 1 || m == 2) ? m : 0;
    endfunction

    function automatic logic [31:0] exp_tgt(input bit t, input logic [31:0] pc, input logic [15:0] d);
        int signed sd;
        sd = int'($signed(d));
        if (t) return pc + 32'd4 + 32'(sd * 4);
        return pc + 32'd8;
    endfunction

    task automatic check_counts(input string req);
        chk({req, " branch count"}, 64'(branch_count_o), 64'(m_br));
        for (int p = 0; p < 3; p++)
            chk({req, " miss slice"}, 64'(miss_count_o[p*CNT_W +: CNT_W]), 64'(m_miss[p]));
    endtask

    task automatic do_fetch(input int tag, input int m, input logic [31:0] pc,
                            input logic [15:0] d, input bit h);
        @(negedge clk);
        fetch_valid_i = 1'b1; fetch_tag_i = TAG_W'(tag); mode_i = 2'(m);
        pc_i = pc; disp_i = d; hint_i = h;
        @(negedge clk);
        fetch_valid_i = 1'b0;
        m_dir[tag] = exp_dir(m, d, h);
        m_pol[tag] = pol_of(m);
    endtask

    task automatic do_resolve(input int tag, input bit taken, input string req);
        bit miss;
        @(negedge clk);
        res_valid_i = 1'b1; res_tag_i = TAG_W'(tag); res_taken_i = taken;
        miss = (m_dir[tag] != taken);
        @(negedge clk);
        res_valid_i = 1'b0;
        m_br++;
        if (miss) m_miss[m_pol[tag]]++;
        chk({req, " mispredict pulse"}, 64'(mispredict_o), 64'(miss));
        check_counts(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] dl [6];
        logic [31:0] pl [3];
        bit t;
        dl = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        pl = '{32'h0000_0000, 32'hFFFF_FFF8, 32'h0000_1000};
        m_br = 0;
        for (int p = 0; p < 3; p++) m_miss[p] = 0;
        for (int i = 0; i < 4; i++) begin m_dir[i] = 1'b0; m_pol[i] = 0; end

        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 mispredict after reset", 64'(mispredict_o), 64'd0);
        check_counts("R10");

        // R1 R2 R3 R4 R5 R6: exhaustive policy / hint sweep over chosen PCs and displacements
        for (int m = 0; m < 4; m++)
            for (int h = 0; h < 2; h++)
                for (int di = 0; di < 6; di++)
                    for (int pi = 0; pi < 3; pi++) begin
                        mode_i = 2'(m); hint_i = h[0]; disp_i = dl[di]; pc_i = pl[pi];
                        #1;
                        t = exp_dir(m, dl[di], h[0]);
                        chk(m == 0 ? "R1 dir" : m == 1 ? "R2 dir" : m == 2 ? "R3 dir" : "R4 dir",
                            64'(pred_taken_o), 64'(t));
                        chk(t ? "R5 taken target" : "R6 fall target",
                            64'(pred_target_o), 64'(exp_tgt(t, pl[pi], dl[di])));
                    end

        // R7 R9 R4: record per tag, resolve and charge misses to policies
        do_fetch(0, 1, 32'h100, 16'hFFFC, 1'b0);   // backward: taken
        do_fetch(1, 1, 32'h200, 16'h0010, 1'b1);   // forward: not taken
        do_fetch(2, 2, 32'h300, 16'hFFF0, 1'b0);   // hint 0: not taken
        do_fetch(3, 3, 32'h400, 16'h0020, 1'b0);   // fallback: taken
        do_resolve(0, 1'b1, "R7 hit");
        do_resolve(1, 1'b1, "R9 sign-policy miss");
        do_resolve(2, 1'b1, "R9 hint-policy miss");
        do_resolve(3, 1'b0, "R4 fallback miss");
        do_resolve(2, 1'b0, "R7 hit after miss");
        @(negedge clk);
        chk("R7 pulse single cycle", 64'(mispredict_o), 64'd0);

        // R7: a cycle with fetch_valid low does not change the record
        @(negedge clk);
        fetch_tag_i = 2'd0; mode_i = 2'b01; disp_i = 16'h0004; fetch_valid_i = 1'b0;
        @(negedge clk);
        do_resolve(0, 1'b1, "R7 no write when idle");

        // R11: fetch and resolve same tag on one edge
        @(negedge clk);
        fetch_valid_i = 1'b1; fetch_tag_i = 2'd1; mode_i = 2'b00;
        res_valid_i = 1'b1; res_tag_i = 2'd1; res_taken_i = 1'b0;
        @(negedge clk);
        fetch_valid_i = 1'b0; res_valid_i = 1'b0;
        m_br++;   // old record: not taken -> hit
        chk("R11 resolve sees old record", 64'(mispredict_o), 64'd0);
        check_counts("R11");
        m_dir[1] = 1'b1; m_pol[1] = 0;
        do_resolve(1, 1'b0, "R11 new record used next");

        // R8 R9: saturation with continuous resolves
        do_fetch(0, 0, 32'h500, 16'h0001, 1'b0);
        @(negedge clk);
        res_valid_i = 1'b1; res_tag_i = 2'd0; res_taken_i = 1'b0;
        repeat (65540) @(negedge clk);
        res_valid_i = 1'b0;
        m_br = 65535; m_miss[0] = 65535;
        chk("R8 R9 pulse while missing", 64'(mispredict_o), 64'd1);
        check_counts("R8 R9 saturation");
        @(negedge clk);
        check_counts("R8 R9 holds at top");

        // R10: reset clears again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_br = 0; for (int p = 0; p < 3; p++) m_miss[p] = 0;
        chk("R10 mispredict cleared", 64'(mispredict_o), 64'd0);
        check_counts("R10 cleared");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule